// File: doc/BRIEF.md
# Physical memory protection access checker

This block decides whether one memory access may proceed. It takes the byte address, the length in bytes, the requested read/write/execute rights and whether the requester runs in machine mode. It also takes, for every protection entry, decoded inclusive bounds and a small configuration field. Two security controls shape the decision: a lockdown control that switches entry permissions to a table lookup, and a deny-by-default control that removes the fallback grant.

Entries are examined in ascending index order. The first entry that touches the access decides the outcome. If it holds both the first and the last byte, its rights are used. If it holds only one of them, the access is refused. When no entry touches the access, a fallback rule applies. The result is the granted rights mask, the deciding entry index (or a marker for the fallback rule or for a refusal with no match) and a fault flag. With the default parameters the result is registered and appears one clock after the inputs.

Each entry's configuration field is 6 bits wide: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 matching mode (0 means the entry is off), bit 5 lock. Rights masks use bit 0 read, bit 1 write, bit 2 execute.

Top module: `pmp_access_checker`

## Requirements
- R1: Among entries whose mode field (bits 4:3) is non-zero, the lowest-indexed one that holds the first byte, the last byte or both decides. When it holds both, the index output shows that entry and later entries have no effect.
- R2: When the deciding entry holds exactly one of the two end bytes, the result is fault 1, grant 000 and index all ones, even if a later entry holds the whole access.
- R3: An entry whose mode field is 0 never takes part in a decision. The last byte is address plus length minus one, and a length of 0 counts as a single byte. Bounds are inclusive at both ends.
- R4: With lockdown clear and a full match, a machine-mode access to an entry whose lock bit (bit 5) is 0 is granted 111. Any other access is granted the entry's bits 2:0.
- R5: With lockdown set and a full match, the grant comes from code {lock, R, W, X} in that bit order. Machine mode gets 011 for codes 2, 3 and 14; 100 for 9 and 10; 101 for 11 and 13; 001 for 12 and 15; otherwise 000. Other modes get 100 for 1, 10 and 11; 001 for 2, 4 and 15; 011 for 3 and 6; 101 for 5; 111 for 7; otherwise 000.
- R6: When nothing matches and both security controls are clear, machine mode is granted 111 with index equal to the entry count. Other modes are refused.
- R7: When deny-by-default is set and nothing matches, every mode is refused, whatever the lockdown control holds.
- R8: When lockdown is set, deny-by-default is clear and nothing matches, a machine-mode access that requests no execute is granted 011 with index equal to the entry count. An execute request is refused, and other modes are refused.
- R9: On a full match, fault is 1 exactly when a requested bit is missing from the grant. Every refusal under the fallback rule gives grant 000, index all ones and fault 1.
- R10: Outputs are registered: they show the decision for the inputs present at the previous rising clock edge. While reset is high they hold grant 000, index all ones and fault 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | ADDR_W | Address of the first byte |
| acc_len | input | LEN_W | Access length in bytes (0 counts as 1) |
| req_perm | input | 3 | Requested rights: bit 0 read, bit 1 write, bit 2 execute |
| priv_m | input | 1 | 1 when the requester is in machine mode |
| sec_lockdown | input | 1 | Lockdown control: table-based permissions and restricted fallback |
| sec_deny_default | input | 1 | Deny-by-default control for unmatched accesses |
| ent_lo | input | N_ENT*ADDR_W | Inclusive lower bound per entry, entry i at slice i |
| ent_hi | input | N_ENT*ADDR_W | Inclusive upper bound per entry |
| ent_cfg | input | N_ENT*6 | Configuration per entry (R, W, X, mode[1:0], lock) |
| grant_o | output | 3 | Granted rights mask |
| match_idx_o | output | $clog2(N_ENT+2) | Deciding entry, N_ENT for fallback grant, all ones for refusal without match |
| fault_o | output | 1 | Access refused |

## Verification
Overlapping entries that share an address range show whether the lowest index wins over a later, more permissive entry. Accesses that straddle an entry boundary show that a partial hit refuses the access instead of falling through to a containing entry. Unmatched accesses are driven under all four settings of the two security controls and in both modes, which separates the fallback variants from one another. A sweep over all sixteen lock/rights codes in both modes with every right requested covers the lockdown table. Random entry layouts and accesses are then compared clock by clock against a behavioural model.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

  localparam int CFG_W   = 6;
  localparam int BIT_R   = 0;
  localparam int BIT_W   = 1;
  localparam int BIT_X   = 2;
  localparam int MODE_LO = 3;
  localparam int MODE_HI = 4;
  localparam int BIT_L   = 5;

  typedef logic [2:0] perm_t;

  localparam perm_t P_NONE = 3'b000;
  localparam perm_t P_R    = 3'b001;
  localparam perm_t P_RW   = 3'b011;
  localparam perm_t P_X    = 3'b100;
  localparam perm_t P_RX   = 3'b101;
  localparam perm_t P_RWX  = 3'b111;

  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_FULL = 2'd1,
    HIT_PART = 2'd2
  } hit_kind_e;

  // Lockdown permission table, code = {lock, R, W, X}
  function automatic perm_t lockdown_perm(input logic [3:0] code, input logic m_mode);
    perm_t p;
    p = P_NONE;
    if (m_mode) begin
      unique case (code)
        4'd2, 4'd3, 4'd14: p = P_RW;
        4'd9, 4'd10:       p = P_X;
        4'd11, 4'd13:      p = P_RX;
        4'd12, 4'd15:      p = P_R;
        default:           p = P_NONE;
      endcase
    end else begin
      unique case (code)
        4'd1, 4'd10, 4'd11: p = P_X;
        4'd2, 4'd4, 4'd15:  p = P_R;
        4'd3, 4'd6:         p = P_RW;
        4'd5:               p = P_RX;
        4'd7:               p = P_RWX;
        default:            p = P_NONE;
      endcase
    end
    return p;
  endfunction

endpackage

// File: rtl/pmp_entry_match.sv
module pmp_entry_match
  import pmp_chk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic              active,
  input  logic [ADDR_W-1:0] first_b,
  input  logic [ADDR_W-1:0] last_b,
  output hit_kind_e         kind
);

  logic first_in;
  logic last_in;

  assign first_in = (first_b >= lo) && (first_b <= hi);
  assign last_in  = (last_b  >= lo) && (last_b  <= hi);

  always_comb begin
    if (!active)                 kind = HIT_NONE;
    else if (first_in && last_in) kind = HIT_FULL;
    else if (first_in || last_in) kind = HIT_PART;
    else                          kind = HIT_NONE;
  end

endmodule

// File: rtl/pmp_prio_pick.sv
module pmp_prio_pick #(
  parameter int N_ENT = 8,
  parameter int SEL_W = 3
) (
  input  logic [N_ENT-1:0] full_v,
  input  logic [N_ENT-1:0] part_v,
  output logic             found,
  output logic             is_full,
  output logic [SEL_W-1:0] sel
);

  // Scan from the top down so that the lowest hit is the last one kept
  always_comb begin
    found   = 1'b0;
    is_full = 1'b0;
    sel     = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (full_v[i] || part_v[i]) begin
        found   = 1'b1;
        is_full = full_v[i];
        sel     = SEL_W'(i);
      end
    end
  end

endmodule

// File: rtl/pmp_grant_calc.sv
module pmp_grant_calc
  import pmp_chk_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  input  logic             m_mode,
  input  logic             lockdown,
  input  logic             deny_default,
  input  perm_t            req,
  output perm_t            hit_grant,
  output perm_t            dflt_mask,
  output logic             dflt_allow
);

  logic [3:0] code;
  perm_t      own_rwx;

  assign own_rwx = perm_t'(cfg[BIT_X:BIT_R]);
  assign code    = {cfg[BIT_L], cfg[BIT_R], cfg[BIT_W], cfg[BIT_X]};

  // Grant of the deciding entry
  always_comb begin
    if (lockdown)                     hit_grant = lockdown_perm(code, m_mode);
    else if (m_mode && !cfg[BIT_L])   hit_grant = P_RWX;
    else                              hit_grant = own_rwx;
  end

  // Fallback rule when no entry touches the access
  always_comb begin
    if (deny_default)  dflt_mask = P_NONE;
    else if (lockdown) dflt_mask = m_mode ? P_RW  : P_NONE;
    else               dflt_mask = m_mode ? P_RWX : P_NONE;
  end

  assign dflt_allow = (dflt_mask != P_NONE) && ((req & ~dflt_mask) == P_NONE);

endmodule

// File: rtl/pmp_access_checker.sv
module pmp_access_checker
  import pmp_chk_pkg::*;
#(
  parameter int N_ENT   = 8,
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 4,
  parameter int OUT_REG = 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            acc_addr,
  input  logic [LEN_W-1:0]             acc_len,
  input  logic [2:0]                   req_perm,
  input  logic                         priv_m,
  input  logic                         sec_lockdown,
  input  logic                         sec_deny_default,
  input  logic [N_ENT*ADDR_W-1:0]      ent_lo,
  input  logic [N_ENT*ADDR_W-1:0]      ent_hi,
  input  logic [N_ENT*6-1:0]           ent_cfg,
  output logic [2:0]                   grant_o,
  output logic [$clog2(N_ENT+2)-1:0]   match_idx_o,
  output logic                         fault_o
);

  localparam int IDX_W = $clog2(N_ENT + 2);
  localparam int SEL_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam logic [IDX_W-1:0] IDX_NONE = '1;
  localparam logic [IDX_W-1:0] IDX_DFLT = IDX_W'(N_ENT);

  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] last_b;
  logic [N_ENT-1:0]  full_v;
  logic [N_ENT-1:0]  part_v;
  logic [CFG_W-1:0]  cfg_a [N_ENT];

  assign span   = (acc_len == '0) ? '0 : ADDR_W'(acc_len) - ADDR_W'(1);
  assign last_b = acc_addr + span;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    hit_kind_e kind;
    assign cfg_a[g] = ent_cfg[g*CFG_W +: CFG_W];

    pmp_entry_match #(.ADDR_W(ADDR_W)) u_match (
      .lo      (ent_lo[g*ADDR_W +: ADDR_W]),
      .hi      (ent_hi[g*ADDR_W +: ADDR_W]),
      .active  (cfg_a[g][MODE_HI:MODE_LO] != 2'b00),
      .first_b (acc_addr),
      .last_b  (last_b),
      .kind    (kind)
    );

    assign full_v[g] = (kind == HIT_FULL);
    assign part_v[g] = (kind == HIT_PART);
  end

  logic             found;
  logic             pick_full;
  logic [SEL_W-1:0] pick_sel;

  pmp_prio_pick #(.N_ENT(N_ENT), .SEL_W(SEL_W)) u_pick (
    .full_v  (full_v),
    .part_v  (part_v),
    .found   (found),
    .is_full (pick_full),
    .sel     (pick_sel)
  );

  perm_t hit_grant;
  perm_t dflt_mask;
  logic  dflt_allow;

  pmp_grant_calc u_grant (
    .cfg          (cfg_a[pick_sel]),
    .m_mode       (priv_m),
    .lockdown     (sec_lockdown),
    .deny_default (sec_deny_default),
    .req          (req_perm),
    .hit_grant    (hit_grant),
    .dflt_mask    (dflt_mask),
    .dflt_allow   (dflt_allow)
  );

  perm_t            grant_c;
  logic [IDX_W-1:0] idx_c;
  logic             fault_c;

  always_comb begin
    if (found && pick_full) begin
      grant_c = hit_grant;
      idx_c   = IDX_W'(pick_sel);
      fault_c = (req_perm & ~hit_grant) != P_NONE;
    end else if (found) begin
      grant_c = P_NONE;
      idx_c   = IDX_NONE;
      fault_c = 1'b1;
    end else if (dflt_allow) begin
      grant_c = dflt_mask;
      idx_c   = IDX_DFLT;
      fault_c = 1'b0;
    end else begin
      grant_c = P_NONE;
      idx_c   = IDX_NONE;
      fault_c = 1'b1;
    end
  end

  if (OUT_REG != 0) begin : g_reg
    logic live_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        grant_o     <= P_NONE;
        match_idx_o <= IDX_NONE;
        fault_o     <= 1'b0;
        live_q      <= 1'b0;
      end else begin
        grant_o     <= grant_c;
        match_idx_o <= idx_c;
        fault_o     <= fault_c;
        live_q      <= 1'b1;
      end
    end

    AST_GRANT_COVERS_REQ: assert property (@(posedge clk) disable iff (rst)
      live_q && !fault_o |-> (($past(req_perm) & ~grant_o) == 3'b000)); // R9

    AST_REFUSAL_SHAPE: assert property (@(posedge clk) disable iff (rst)
      live_q && (match_idx_o == IDX_NONE) |-> fault_o && (grant_o == 3'b000)); // R9

    AST_FALLBACK_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
      live_q && (match_idx_o == IDX_DFLT) |-> !fault_o && $past(priv_m)); // R6

    AST_DENY_NO_FALLBACK: assert property (@(posedge clk) disable iff (rst)
      live_q && $past(sec_deny_default) |-> (match_idx_o != IDX_DFLT)); // R7

    AST_LOCKDOWN_FALLBACK_RW: assert property (@(posedge clk) disable iff (rst)
      live_q && $past(sec_lockdown) && (match_idx_o == IDX_DFLT) |-> (grant_o == P_RW)); // R8
  end else begin : g_comb
    assign grant_o     = grant_c;
    assign match_idx_o = idx_c;
    assign fault_o     = fault_c;
  end

endmodule

// File: tb/pmp_access_checker_tb.sv
`timescale 1ns/1ps
module pmp_access_checker_tb;

  localparam int N   = 8;
  localparam int AW  = 32;
  localparam int LW  = 4;
  localparam int IW  = 4;
  localparam int NONE_IDX = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [AW-1:0] a_addr = '0;
  logic [LW-1:0] a_len  = '0;
  logic [2:0]    a_req  = '0;
  logic          a_m    = 1'b0;
  logic          s_lock = 1'b0;
  logic          s_deny = 1'b0;
  logic [AW-1:0] lo_a  [N];
  logic [AW-1:0] hi_a  [N];
  logic [5:0]    cfg_a [N];
  logic [N*AW-1:0] lo_f, hi_f;
  logic [N*6-1:0]  cfg_f;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      lo_f[i*AW +: AW] = lo_a[i];
      hi_f[i*AW +: AW] = hi_a[i];
      cfg_f[i*6 +: 6]  = cfg_a[i];
    end
  end

  logic [2:0]    g_o;
  logic [IW-1:0] i_o;
  logic          f_o;

  pmp_access_checker u_dut (
    .clk(clk), .rst(rst), .acc_addr(a_addr), .acc_len(a_len), .req_perm(a_req),
    .priv_m(a_m), .sec_lockdown(s_lock), .sec_deny_default(s_deny),
    .ent_lo(lo_f), .ent_hi(hi_f), .ent_cfg(cfg_f),
    .grant_o(g_o), .match_idx_o(i_o), .fault_o(f_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  string cur_tag = "R10";

  // Lockdown table written from the requirement text (R5)
  function automatic logic [2:0] ref_table(int code, bit m);
    if (m) begin
      case (code)
        2, 3, 14: return 3'b011;
        9, 10:    return 3'b100;
        11, 13:   return 3'b101;
        12, 15:   return 3'b001;
        default:  return 3'b000;
      endcase
    end
    case (code)
      1, 10, 11: return 3'b100;
      2, 4, 15:  return 3'b001;
      3, 6:      return 3'b011;
      5:         return 3'b101;
      7:         return 3'b111;
      default:   return 3'b000;
    endcase
  endfunction

  task automatic ref_model(output logic [2:0] g, output int idx, output bit f);
    longint first, last;
    logic [2:0] dm;
    first = a_addr;
    last  = first + ((a_len == 0) ? 0 : a_len - 1);
    for (int i = 0; i < N; i++) begin
      bit in_a, in_b;
      if (cfg_a[i][4:3] == 2'b00) continue;
      in_a = (first >= longint'(lo_a[i])) && (first <= longint'(hi_a[i]));
      in_b = (last  >= longint'(lo_a[i])) && (last  <= longint'(hi_a[i]));
      if (in_a && in_b) begin
        if (s_lock)
          g = ref_table({cfg_a[i][5], cfg_a[i][0], cfg_a[i][1], cfg_a[i][2]}, a_m);
        else if (a_m && !cfg_a[i][5]) g = 3'b111;
        else g = cfg_a[i][2:0];
        idx = i;
        f = (a_req & ~g) != 0;
        return;
      end
      if (in_a || in_b) begin
        g = 0; idx = NONE_IDX; f = 1; return;
      end
    end
    if (s_deny) dm = 0;
    else if (s_lock) dm = a_m ? 3'b011 : 3'b000;
    else dm = a_m ? 3'b111 : 3'b000;
    if (dm != 0 && (a_req & ~dm) == 0) begin
      g = dm; idx = N; f = 0;
    end else begin
      g = 0; idx = NONE_IDX; f = 1;
    end
  endtask

  logic [2:0] e_g;
  int         e_i;
  bit         e_f;
  bit         have_exp = 0;
  string      e_tag;

  always @(posedge clk) begin
    if (rst) begin
      e_g = 0; e_i = NONE_IDX; e_f = 0; e_tag = "R10";
    end else begin
      ref_model(e_g, e_i, e_f);
      e_tag = cur_tag;
    end
    have_exp = 1;
  end

  always @(negedge clk) begin
    if (have_exp) begin
      n_chk++;
      if (g_o !== e_g || int'(i_o) != e_i || f_o !== e_f) begin
        n_bad++;
        $display("FAIL %s grant=%b/%b idx=%0d/%0d fault=%b/%b (actual/expected)",
                 e_tag, g_o, e_g, i_o, e_i, f_o, e_f);
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  task automatic go(string tag, logic [AW-1:0] ad, int ln, logic [2:0] rq, bit m);
    @(negedge clk);
    cur_tag = tag; a_addr = ad; a_len = LW'(ln); a_req = rq; a_m = m;
  endtask

  task automatic set_ent(int i, logic [AW-1:0] l, logic [AW-1:0] h, logic [5:0] c);
    lo_a[i] = l; hi_a[i] = h; cfg_a[i] = c;
  endtask

  // cfg: {lock, mode[1:0], X, W, R}
  initial begin
    for (int i = 0; i < N; i++) set_ent(i, 0, 0, 6'd0);
    go("R10", 32'h100, 4, 3'b001, 1);
    go("R10", 32'h100, 4, 3'b001, 0);
    go("R10", 32'h100, 4, 3'b001, 1);
    @(negedge clk); rst = 1'b0;
    // no active entries
    go("R6", 32'h1000, 4, 3'b111, 1);
    go("R6", 32'h1000, 4, 3'b001, 0);
    go("R6", 32'h1000, 0, 3'b000, 0);
    // overlapping layout
    @(negedge clk);
    set_ent(0, 32'h1000, 32'h1FFF, 6'b0_01_001);
    set_ent(1, 32'h1000, 32'h3FFF, 6'b0_01_011);
    set_ent(2, 32'h8000, 32'h8FFF, 6'b0_00_111);
    set_ent(3, 32'h4000, 32'h4FFF, 6'b1_11_001);
    go("R1", 32'h1800, 4, 3'b001, 0);
    go("R9", 32'h1800, 4, 3'b010, 0);
    go("R1", 32'h2000, 4, 3'b011, 0);
    go("R1", 32'h3FFC, 4, 3'b010, 0);
    go("R4", 32'h1800, 4, 3'b110, 1);
    go("R4", 32'h4000, 4, 3'b010, 1);
    go("R4", 32'h4000, 8, 3'b001, 0);
    go("R2", 32'h1FFE, 4, 3'b001, 0);
    go("R2", 32'h0FFE, 4, 3'b001, 1);
    go("R2", 32'h3FFE, 4, 3'b001, 1);
    go("R3", 32'h8000, 4, 3'b001, 0);
    go("R3", 32'h8000, 4, 3'b111, 1);
    go("R3", 32'h1FFF, 0, 3'b001, 0);
    go("R3", 32'h1FFF, 1, 3'b001, 0);
    go("R3", 32'h1FFF, 2, 3'b001, 0);
    go("R3", 32'h1000, 15, 3'b001, 0);
    // fallback variants
    s_deny = 1'b1;
    go("R7", 32'h9000, 4, 3'b001, 1);
    go("R7", 32'h9000, 4, 3'b000, 1);
    go("R7", 32'h9000, 4, 3'b001, 0);
    go("R7", 32'h1800, 4, 3'b001, 0);
    s_lock = 1'b1;
    go("R7", 32'h9000, 4, 3'b001, 1);
    s_deny = 1'b0;
    go("R8", 32'h9000, 4, 3'b011, 1);
    go("R8", 32'h9000, 4, 3'b100, 1);
    go("R8", 32'h9000, 4, 3'b001, 0);
    go("R8", 32'h9000, 4, 3'b000, 1);
    // lockdown table sweep on entry 0
    for (int code = 0; code < 16; code++) begin
      for (int m = 0; m < 2; m++) begin
        @(negedge clk);
        set_ent(0, 32'h100, 32'h1FF,
                {code[3], 2'b01, code[0], code[1], code[2]});
        go("R5", 32'h140, 4, 3'b111, bit'(m));
      end
    end
    // random layouts
    for (int blk = 0; blk < 20; blk++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        logic [AW-1:0] b;
        b = AW'($urandom_range(0, 32'h3000));
        set_ent(i, b, b + AW'($urandom_range(0, 32'h1800)), 6'($urandom));
      end
      s_lock = 1'($urandom);
      s_deny = 1'($urandom_range(0, 3) == 0);
      for (int k = 0; k < 40; k++)
        go("R1", AW'($urandom_range(0, 32'h5000)), $urandom_range(0, 15),
           3'($urandom), 1'($urandom));
    end
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule